// File: doc/BRIEF.md
# Dead-Time Complementary PWM Generator

This block drives three half-bridge phases with complementary PWM. Two counters step in lockstep, both up or both down. The lead counter sits a fixed dead-time distance above the lag counter. Each phase has a positive output and a negative output. The positive output is active while the lead counter is below the phase duty. The negative output is active while the lag counter is at or above that duty. Because the two counters are offset, the pair is never active at once, and both sit inactive for the dead-time span around every duty crossing.

The period limit, the lag limit and the three duty values are working registers. Each one is fed from a shadow register. A simple write port programs the shadows, the dead time and two shadow-enable bits. With shadowing on, a write only reaches the working copy at the next trough, which is the cycle where the lag counter is zero while counting is requested. A level `start` input runs the counters. Dropping `start` parks them in their initial state, so a later restart needs no reload.

Top module: `cpwm_deadtime`

## Requirements
- R1: After reset the lead counter reads 4, the lag counter reads 0, and all six outputs are 0. The period limit is 100, the lag limit is 96, the duties are 0, the dead time is 4, and both shadow enables are 0.
- R2: While `start` is high, the lag counter starts from 0 and rises by one per clock. The up-count reverses when the lead counter reaches the period limit or the lag counter reaches the lag limit, whichever comes first. The down-count runs back to 0 and reverses again.
- R3: While counting, the lead counter minus the lag counter stays constant. It equals the dead time captured at the last stopped cycle.
- R4: On every clock with `start` low, the lead counter is loaded with the dead-time register, the lag counter is loaded with 0, and the direction is set to up. All outputs are 0 while stopped.
- R5: When `start` rises again, counting resumes from that parked state without any counter write.
- R6: Phase k's positive output equals running AND (lead < duty k). Its negative output equals running AND (lag >= duty k). Both edges occur in both count directions.
- R7: For each phase, the positive and negative outputs are never both 1.
- R8: Register addresses are: 0 period limit, 1 lag limit, 2/3/4 duty of phase 0/1/2, 5 dead time, 6 control. Control bit 0 enables shadowing for addresses 0, 1 and 2. While that bit is set, writes to those addresses land only in the shadow. All shadows are copied to the working registers on the edge that leaves a trough.
- R9: Control bit 1 enables shadowing in the same way for addresses 3 and 4.
- R10: With the matching control bit clear, a write updates the working register on the next edge. This also holds while counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Level: 1 counts, 0 parks the counters |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Register write data |
| pwm_pos | output | 3 | Positive-phase outputs, one per phase |
| pwm_neg | output | 3 | Negative-phase outputs, one per phase |
| cnt_lead | output | 16 | Lead counter value |
| cnt_lag | output | 16 | Lag counter value |

## Verification
A wrong offset or direction bit shows on the counter ports at the next clock. It then shifts every output edge in the same period. A shadow copied at the wrong moment shows as an output edge that moves one period early or late, relative to a duty change written mid-period. A bad parked state shows on the first clock after `start` falls, and again as a shifted first period after restart. The scoreboard compares both counters and all six outputs on every clock, so any such fault is reported within one cycle of its first visible effect.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;
    localparam int CPWM_W   = 16;
    localparam int CPWM_PH  = 3;
    localparam int CPWM_DT0 = 4;
    localparam int CPWM_CY0 = 100;
    localparam int CPWM_CD0 = 96;

    typedef enum logic {DIR_UP = 1'b0, DIR_DOWN = 1'b1} cnt_dir_e;

    // registers 0..1 are limits, 2.. are duties
    function automatic int reg_count(input int nph);
        return nph + 2;
    endfunction

    // shadow group: 0 = control bit 0, 1 = control bit 1
    function automatic int reg_group(input int idx);
        return (idx <= 2) ? 0 : 1;
    endfunction
endpackage

// File: rtl/cpwm_regs.sv
module cpwm_regs
    import cpwm_pkg::*;
#(
    parameter int W      = CPWM_W,
    parameter int NPH    = CPWM_PH,
    parameter int DT_RST = CPWM_DT0,
    parameter int CY_RST = CPWM_CY0,
    parameter int CD_RST = CPWM_CD0,
    parameter int AW     = 3
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    we,
    input  logic [AW-1:0]           addr,
    input  logic [W-1:0]            wdata,
    input  logic                    xfer,
    output logic [W-1:0]            eff_cyc,
    output logic [W-1:0]            eff_cd,
    output logic [NPH-1:0][W-1:0]   duty,
    output logic [W-1:0]            dt
);
    localparam int NREG = reg_count(NPH);
    localparam int A_DT = NREG;
    localparam int A_CT = NREG + 1;

    logic [1:0]   ctrl;
    logic [W-1:0] shadow [NREG];
    logic [W-1:0] work   [NREG];

    always_ff @(posedge clk) begin
        if (rst) begin
            dt   <= W'(DT_RST);
            ctrl <= '0;
        end else if (we && addr == AW'(A_DT)) begin
            dt <= wdata;
        end else if (we && addr == AW'(A_CT)) begin
            ctrl <= wdata[1:0];
        end
    end

    for (genvar k = 0; k < NREG; k++) begin : g_reg
        localparam int GRP = reg_group(k);
        localparam logic [W-1:0] RV = (k == 0) ? W'(CY_RST) :
                                      (k == 1) ? W'(CD_RST) : '0;
        logic hit;
        assign hit = we && (addr == AW'(k));

        always_ff @(posedge clk) begin
            if (rst) begin
                shadow[k] <= RV;
                work[k]   <= RV;
            end else begin
                if (hit) shadow[k] <= wdata;
                if (hit && !ctrl[GRP]) work[k] <= wdata;
                else if (xfer)         work[k] <= shadow[k];
            end
        end

        if (k >= 2) begin : g_duty
            assign duty[k-2] = work[k];
        end

        p_shadow_hold_r8: assert property (@(posedge clk) disable iff (rst)
            (GRP == 0 && ctrl[0] && !xfer) |=> $stable(work[k]))
            else $error("working register changed outside a trough");
        p_shadow_hold_r9: assert property (@(posedge clk) disable iff (rst)
            (GRP == 1 && ctrl[1] && !xfer) |=> $stable(work[k]))
            else $error("working duty changed outside a trough");
    end

    assign eff_cyc = xfer ? shadow[0] : work[0];
    assign eff_cd  = xfer ? shadow[1] : work[1];
endmodule

// File: rtl/cpwm_counter.sv
module cpwm_counter
    import cpwm_pkg::*;
#(
    parameter int W      = CPWM_W,
    parameter int DT_RST = CPWM_DT0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] dt,
    input  logic [W-1:0] lim_lead,
    input  logic [W-1:0] lim_lag,
    output logic [W-1:0] lead,
    output logic [W-1:0] lag,
    output logic         run,
    output logic         xfer
);
    localparam logic [W-1:0] ONE = W'(1);

    cnt_dir_e     dir;
    logic [W-1:0] lead_up, lag_up;

    assign lead_up = lead + ONE;
    assign lag_up  = lag + ONE;
    assign xfer    = start && (lag == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            lead <= W'(DT_RST);
            lag  <= '0;
            dir  <= DIR_UP;
            run  <= 1'b0;
        end else begin
            run <= start;
            if (!start) begin
                lead <= dt;
                lag  <= '0;
                dir  <= DIR_UP;
            end else if (dir == DIR_UP) begin
                lead <= lead_up;
                lag  <= lag_up;
                if (lead_up >= lim_lead || lag_up >= lim_lag) dir <= DIR_DOWN;
            end else begin
                lead <= lead - ONE;
                lag  <= lag - ONE;
                if (lag == ONE) dir <= DIR_UP;
            end
        end
    end

    p_offset_kept_r3: assert property (@(posedge clk) disable iff (rst)
        start |=> (W'(lead - lag) == $past(W'(lead - lag))))
        else $error("counter offset drifted");
    p_park_state_r4: assert property (@(posedge clk) disable iff (rst)
        !start |=> (lead == $past(dt) && lag == '0))
        else $error("parked counter state wrong");
endmodule

// File: rtl/cpwm_outgen.sv
module cpwm_outgen
    import cpwm_pkg::*;
#(
    parameter int W   = CPWM_W,
    parameter int NPH = CPWM_PH
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  run,
    input  logic [W-1:0]          lead,
    input  logic [W-1:0]          lag,
    input  logic [NPH-1:0][W-1:0] duty,
    output logic [NPH-1:0]        pos,
    output logic [NPH-1:0]        neg
);
    for (genvar k = 0; k < NPH; k++) begin : g_ph
        assign pos[k] = run && (lead < duty[k]);
        assign neg[k] = run && (lag >= duty[k]);

        p_no_overlap_r7: assert property (@(posedge clk) disable iff (rst)
            !(pos[k] && neg[k]))
            else $error("phase outputs overlap");
    end
endmodule

// File: rtl/cpwm_deadtime.sv
module cpwm_deadtime
    import cpwm_pkg::*;
#(
    parameter int W      = CPWM_W,
    parameter int NPH    = CPWM_PH,
    parameter int DT_RST = CPWM_DT0,
    parameter int CY_RST = CPWM_CY0,
    parameter int CD_RST = CPWM_CD0,
    localparam int AW    = $clog2(reg_count(NPH) + 2)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic           wr_en,
    input  logic [AW-1:0]  wr_addr,
    input  logic [W-1:0]   wr_data,
    output logic [NPH-1:0] pwm_pos,
    output logic [NPH-1:0] pwm_neg,
    output logic [W-1:0]   cnt_lead,
    output logic [W-1:0]   cnt_lag
);
    logic [W-1:0]          eff_cyc, eff_cd, dt;
    logic [NPH-1:0][W-1:0] duty;
    logic                  run, xfer;

    cpwm_regs #(.W(W), .NPH(NPH), .DT_RST(DT_RST), .CY_RST(CY_RST),
                .CD_RST(CD_RST), .AW(AW)) u_regs (
        .clk(clk), .rst(rst), .we(wr_en), .addr(wr_addr), .wdata(wr_data),
        .xfer(xfer), .eff_cyc(eff_cyc), .eff_cd(eff_cd), .duty(duty), .dt(dt)
    );

    cpwm_counter #(.W(W), .DT_RST(DT_RST)) u_cnt (
        .clk(clk), .rst(rst), .start(start), .dt(dt),
        .lim_lead(eff_cyc), .lim_lag(eff_cd),
        .lead(cnt_lead), .lag(cnt_lag), .run(run), .xfer(xfer)
    );

    cpwm_outgen #(.W(W), .NPH(NPH)) u_out (
        .clk(clk), .rst(rst), .run(run), .lead(cnt_lead), .lag(cnt_lag),
        .duty(duty), .pos(pwm_pos), .neg(pwm_neg)
    );

    p_stop_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(start) |=> (pwm_pos == '0 && pwm_neg == '0))
        else $error("outputs active after stop");
endmodule

// File: tb/test_cpwm_deadtime.sv
module test_cpwm_deadtime;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [2:0]  pwm_pos, pwm_neg;
    logic [15:0] cnt_lead, cnt_lag;

    always #5 clk = ~clk;

    cpwm_deadtime i_cpwm_deadtime (
        .clk(clk), .rst(rst), .start(start), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .pwm_pos(pwm_pos), .pwm_neg(pwm_neg),
        .cnt_lead(cnt_lead), .cnt_lag(cnt_lag)
    );

    typedef struct {
        logic [15:0] lead, lag;
        logic [2:0]  pos, neg;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0, fails = 0;
    bit   done = 1'b0;

    // reference state, from the requirements
    logic [15:0] m_lead = 16'd4, m_lag = 16'd0, m_dt = 16'd4;
    logic        m_up = 1'b1;
    logic [1:0]  m_ctrl = 2'b00;
    logic [15:0] m_sh [5] = '{16'd100, 16'd96, 16'd0, 16'd0, 16'd0};
    logic [15:0] m_wk [5] = '{16'd100, 16'd96, 16'd0, 16'd0, 16'd0};

    task automatic step(input logic s, input logic w, input logic [2:0] a,
                        input logic [15:0] d, input string tag);
        exp_t e;
        logic xf;
        logic [15:0] ecy, ecd, n1, n2;
        start = s; wr_en = w; wr_addr = a; wr_data = d;
        xf  = s && (m_lag == 16'd0);
        ecy = xf ? m_sh[0] : m_wk[0];
        ecd = xf ? m_sh[1] : m_wk[1];
        if (!s) begin
            m_lead = m_dt; m_lag = 16'd0; m_up = 1'b1;
        end else if (m_up) begin
            n1 = m_lead + 16'd1; n2 = m_lag + 16'd1;
            if (n1 >= ecy || n2 >= ecd) m_up = 1'b0;
            m_lead = n1; m_lag = n2;
        end else begin
            if (m_lag == 16'd1) m_up = 1'b1;
            m_lead = m_lead - 16'd1; m_lag = m_lag - 16'd1;
        end
        if (xf) for (int k = 0; k < 5; k++) m_wk[k] = m_sh[k];
        if (w) begin
            if (a < 3'd5) begin
                m_sh[a] = d;
                if (!m_ctrl[(a <= 3'd2) ? 0 : 1]) m_wk[a] = d;
            end else if (a == 3'd5) m_dt = d;
            else if (a == 3'd6) m_ctrl = d[1:0];
        end
        e.lead = m_lead; e.lag = m_lag; e.tag = tag;
        for (int k = 0; k < 3; k++) begin
            e.pos[k] = s && (m_lead < m_wk[2+k]);
            e.neg[k] = s && (m_lag >= m_wk[2+k]);
        end
        exp_q.push_back(e);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run_n(input int n, input logic s, input string tag);
        for (int i = 0; i < n; i++) step(s, 1'b0, 3'd0, 16'd0, tag);
    endtask

    // monitor: one expected item per clock edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                checks++;
                if (cnt_lead !== e.lead || cnt_lag !== e.lag ||
                    pwm_pos !== e.pos || pwm_neg !== e.neg) begin
                    fails++;
                    $display("FAIL %s: lead=%0d lag=%0d pos=%b neg=%b expected lead=%0d lag=%0d pos=%b neg=%b",
                             e.tag, cnt_lead, cnt_lag, pwm_pos, pwm_neg,
                             e.lead, e.lag, e.pos, e.neg);
                end
                checks++;  // R7 pairwise exclusion
                if ((pwm_pos & pwm_neg) !== 3'b000) begin
                    fails++;
                    $display("FAIL R7: pos=%b neg=%b expected no common bit",
                             pwm_pos, pwm_neg);
                end
            end
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        checks++;  // R1 reset state
        if (cnt_lead !== 16'd4 || cnt_lag !== 16'd0 || pwm_pos !== 3'b0 || pwm_neg !== 3'b0) begin
            fails++;
            $display("FAIL R1: lead=%0d lag=%0d pos=%b neg=%b expected 4 0 000 000",
                     cnt_lead, cnt_lag, pwm_pos, pwm_neg);
        end
        // R10: unbuffered setup while parked
        step(1'b0, 1'b1, 3'd6, 16'd0,  "R10");
        step(1'b0, 1'b1, 3'd5, 16'd2,  "R10 R4");
        step(1'b0, 1'b1, 3'd0, 16'd12, "R10");
        step(1'b0, 1'b1, 3'd1, 16'd10, "R10");
        step(1'b0, 1'b1, 3'd2, 16'd4,  "R10");
        step(1'b0, 1'b1, 3'd3, 16'd6,  "R10");
        step(1'b0, 1'b1, 3'd4, 16'd9,  "R10");
        run_n(50, 1'b1, "R2 R3 R6");
        run_n(4,  1'b0, "R4");
        run_n(30, 1'b1, "R5");
        step(1'b1, 1'b1, 3'd3, 16'd3, "R10 running");
        run_n(12, 1'b1, "R10 R6");
        // shadowed updates: group A and group B
        step(1'b1, 1'b1, 3'd6, 16'd3,  "R8 R9");
        step(1'b1, 1'b1, 3'd0, 16'd20, "R8");
        step(1'b1, 1'b1, 3'd1, 16'd7,  "R8 R2 lag limit");
        step(1'b1, 1'b1, 3'd2, 16'd2,  "R8");
        step(1'b1, 1'b1, 3'd4, 16'd5,  "R9");
        run_n(40, 1'b1, "R8 R9 R2");
        // new dead time only takes effect through the parked state
        step(1'b0, 1'b1, 3'd5, 16'd5, "R4");
        run_n(3, 1'b0, "R4");
        step(1'b1, 1'b1, 3'd1, 16'd30, "R8 R3");
        run_n(60, 1'b1, "R3 R5 R6");
        run_n(2, 1'b0, "R4");
        @(posedge clk); #3;
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule